// File: doc/BRIEF.md
# Action-Qualified PWM Channel

This block is one pulse-width channel. A 16-bit time-base counter runs in one of three counting modes, and a prescaler sets how fast it advances. On each step the channel spots one event: the counter at zero, the counter at its period, or the counter equal to one of two compare values. A compare event also records whether the counter was going up or down. Each of the two outputs looks up that event in its own small action table. The table says whether to keep the output level, clear it, set it, or flip it.

Software sets up the channel through a simple write-only register port. Period and compare values written while the channel runs wait in shadow registers. They take effect only when the counter passes zero, so a running waveform never sees a half-updated setting. While the channel is stopped, each output drives its programmed idle level. While it runs, each output carries its qualified level, inverted when that output's polarity bit asks for it.

Top module: `pwm_action_channel`

## Requirements
- R1: Writes with `cfgWrEn` high land at the next clock edge in the register chosen by `cfgAddr`. The registers are: 0 control, 1 prescale, 2 period, 3 compare A, 4 compare B, 5 action table of output A, 6 action table of output B. The control fields are bit 0 run, bits 2:1 mode (0 up, 1 down, 2 up-down), bits 4:3 invert for B:A, and bits 6:5 idle level for B:A.
- R2: While run is 0, each output equals its idle bit and its qualified level is held at 0. When run is 1, the output is the qualified level XOR the invert bit, and the qualified level starts at 0 when the channel starts.
- R3: While running, a time-base tick happens once every prescale+1 clock cycles. The first tick falls in the (prescale+1)-th cycle after run is set. The counter and the levels change only on ticks.
- R4: In up mode the counter starts at 0, rises by one per tick, and goes back to 0 on the tick after it reaches the period.
- R5: In down mode the counter starts at the period, falls by one per tick, and on the tick at 0 reloads the (shadow) period.
- R6: In up-down mode the counter starts at 0 going up. It turns to counting down on the tick where it reaches the period, and turns to counting up on the tick at 0, going to 1. Both ends raise their events.
- R7: A compare match raises its up-counting event in up mode and in the rising half of up-down mode. It raises its down-counting event in down mode and in the falling half.
- R8: Each action table is 12 bits made of 2-bit fields. From bit 0 upward the fields are: zero, period, B up, B down, A up, A down. The field codes are 0 keep, 1 drive low, 2 drive high, 3 flip.
- R9: Only one event is acted on per tick, in the priority order zero, period, compare B, compare A.
- R10: The polarity bit of an output inverts that output without changing its action sequence.
- R11: Period and compare writes made while running take effect at the first tick with the counter at zero that follows the write. While stopped, they take effect at once.
- R12: The two outputs are qualified independently, each from its own table and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | ADDR_W (3) | Register index |
| cfgWrData | input | CNT_W (16) | Write data |
| pwmOutA | output | 1 | Waveform output A |
| pwmOutB | output | 1 | Waveform output B |

## Verification
A register write shows at the outputs one cycle after its capturing edge. So run, polarity and idle changes are compared in the cycle right after the write. Tick number k acts at the end of cycle k·(prescale+1)+prescale, counted from the first running cycle. The output in running cycle c therefore reflects floor(c/(prescale+1)) ticks. The bench builds those tick-indexed levels from the action tables and compares every cycle. A mid-run period write is mapped to the first tick evaluated after its capturing edge, and that tick then governs the next zero reload.

// File: rtl/pwm_act_pkg.sv
package pwm_act_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_RSVD   = 2'd3
  } cntMode_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  // first member sits in the top bits: field order is zero at bit 0 upward
  typedef struct packed {
    act_e caDown;
    act_e caUp;
    act_e cbDown;
    act_e cbUp;
    act_e atPrd;
    act_e atZero;
  } actTbl_t;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_ZERO,
    EV_PRD,
    EV_CBU,
    EV_CBD,
    EV_CAU,
    EV_CAD
  } evSel_e;

  typedef struct packed {
    logic run;
    logic tick;
  } ctrlStb_t;

  typedef struct packed {
    cntMode_e          mode;
    logic [1:0]        inv;
    logic [1:0]        idle;
    actTbl_t [1:0]     tbl;
  } chanCfg_t;

  localparam int REG_CTRL  = 0;
  localparam int REG_PRESC = 1;
  localparam int REG_PER   = 2;
  localparam int REG_CMPA  = 3;
  localparam int REG_CMPB  = 4;
  localparam int REG_ACTA  = 5;
  localparam int REG_ACTB  = 6;

endpackage

// File: rtl/pwm_act_qual.sv
module pwm_act_qual
  import pwm_act_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    run,
  input  logic    tick,
  input  evSel_e  ev,
  input  actTbl_t tbl,
  output logic    lvl
);

  act_e act;

  always_comb begin
    case (ev)
      EV_ZERO: act = tbl.atZero;
      EV_PRD:  act = tbl.atPrd;
      EV_CBU:  act = tbl.cbUp;
      EV_CBD:  act = tbl.cbDown;
      EV_CAU:  act = tbl.caUp;
      EV_CAD:  act = tbl.caDown;
      default: act = ACT_KEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl <= 1'b0;
    end else if (!run) begin
      lvl <= 1'b0;
    end else if (tick) begin
      case (act)
        ACT_LOW:  lvl <= 1'b0;
        ACT_HIGH: lvl <= 1'b1;
        ACT_FLIP: lvl <= ~lvl;
        default:  lvl <= lvl;
      endcase
    end
  end

endmodule

// File: rtl/pwm_act_ctrl.sv
module pwm_act_ctrl
  import pwm_act_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgWrData,
  output ctrlStb_t          stb,
  output chanCfg_t          cfg,
  output logic [CNT_W-1:0]  shPer,
  output logic [CNT_W-1:0]  shCa,
  output logic [CNT_W-1:0]  shCb
);

  localparam int ACT_W = $bits(actTbl_t);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(REG_PRESC);
  localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(REG_PER);
  localparam logic [ADDR_W-1:0] A_CMPA  = ADDR_W'(REG_CMPA);
  localparam logic [ADDR_W-1:0] A_CMPB  = ADDR_W'(REG_CMPB);
  localparam logic [ADDR_W-1:0] A_ACTA  = ADDR_W'(REG_ACTA);
  localparam logic [ADDR_W-1:0] A_ACTB  = ADDR_W'(REG_ACTB);
  localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

  logic             runReg;
  chanCfg_t         cfgReg;
  logic [CNT_W-1:0] presc;
  logic [CNT_W-1:0] psCnt;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg <= 1'b0;
      cfgReg <= '0;
      presc  <= '0;
      shPer  <= '0;
      shCa   <= '0;
      shCb   <= '0;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        A_CTRL: begin
          runReg      <= cfgWrData[0];
          cfgReg.mode <= cntMode_e'(cfgWrData[2:1]);
          cfgReg.inv  <= cfgWrData[4:3];
          cfgReg.idle <= cfgWrData[6:5];
        end
        A_PRESC: presc <= cfgWrData;
        A_PER:   shPer <= cfgWrData;
        A_CMPA:  shCa  <= cfgWrData;
        A_CMPB:  shCb  <= cfgWrData;
        A_ACTA:  cfgReg.tbl[0] <= actTbl_t'(cfgWrData[ACT_W-1:0]);
        A_ACTB:  cfgReg.tbl[1] <= actTbl_t'(cfgWrData[ACT_W-1:0]);
        default: ;
      endcase
    end
  end

  assign tick = runReg && (psCnt == presc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (!runReg || tick) begin
      psCnt <= '0;
    end else begin
      psCnt <= psCnt + ONE;
    end
  end

  assign stb.run  = runReg;
  assign stb.tick = tick;
  assign cfg      = cfgReg;

endmodule

// File: rtl/pwm_act_dp.sv
module pwm_act_dp
  import pwm_act_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_OUT   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  chanCfg_t         cfg,
  input  logic [CNT_W-1:0] shPer,
  input  logic [CNT_W-1:0] shCa,
  input  logic [CNT_W-1:0] shCb,
  output logic [N_OUT-1:0] pwmOut,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] actPer,
  output logic             dirUp
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ, cntNxt, actPerQ, actCaQ, actCbQ;
  logic             dirQ, dirNxt, dirEff, atZero;
  evSel_e           evSel;
  logic [N_OUT-1:0] lvl;

  assign atZero = (cntQ == '0);

  always_comb begin
    case (cfg.mode)
      MODE_DOWN:   dirEff = 1'b0;
      MODE_UPDOWN: dirEff = dirQ;
      default:     dirEff = 1'b1;
    endcase
  end

  // priority: zero, period, compare B, compare A
  always_comb begin
    if (atZero)                evSel = EV_ZERO;
    else if (cntQ == actPerQ)  evSel = EV_PRD;
    else if (cntQ == actCbQ)   evSel = dirEff ? EV_CBU : EV_CBD;
    else if (cntQ == actCaQ)   evSel = dirEff ? EV_CAU : EV_CAD;
    else                       evSel = EV_NONE;
  end

  always_comb begin
    cntNxt = cntQ;
    dirNxt = dirQ;
    case (cfg.mode)
      MODE_DOWN: cntNxt = atZero ? shPer : cntQ - ONE;
      MODE_UPDOWN: begin
        if (dirQ) begin
          if (cntQ >= actPerQ) begin
            dirNxt = 1'b0;
            cntNxt = atZero ? '0 : cntQ - ONE;
          end else begin
            cntNxt = cntQ + ONE;
          end
        end else if (atZero) begin
          dirNxt = 1'b1;
          cntNxt = (shPer == '0) ? '0 : ONE;
        end else begin
          cntNxt = cntQ - ONE;
        end
      end
      default: cntNxt = (cntQ >= actPerQ) ? '0 : cntQ + ONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      dirQ    <= 1'b1;
      actPerQ <= '0;
      actCaQ  <= '0;
      actCbQ  <= '0;
    end else if (!stb.run) begin
      cntQ    <= (cfg.mode == MODE_DOWN) ? shPer : '0;
      dirQ    <= 1'b1;
      actPerQ <= shPer;
      actCaQ  <= shCa;
      actCbQ  <= shCb;
    end else if (stb.tick) begin
      cntQ <= cntNxt;
      dirQ <= dirNxt;
      if (atZero) begin
        actPerQ <= shPer;
        actCaQ  <= shCa;
        actCbQ  <= shCb;
      end
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    pwm_act_qual u_qual (
      .clk  (clk),
      .rstN (rstN),
      .run  (stb.run),
      .tick (stb.tick),
      .ev   (evSel),
      .tbl  (cfg.tbl[i]),
      .lvl  (lvl[i])
    );
    assign pwmOut[i] = stb.run ? (lvl[i] ^ cfg.inv[i]) : cfg.idle[i];
  end

  assign cnt    = cntQ;
  assign actPer = actPerQ;
  assign dirUp  = dirEff;

endmodule

// File: rtl/pwm_action_channel.sv
module pwm_action_channel
  import pwm_act_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgWrData,
  output logic              pwmOutA,
  output logic              pwmOutB
);

  localparam int N_OUT = 2;

  ctrlStb_t         stb;
  chanCfg_t         cfg;
  logic [CNT_W-1:0] shPer, shCa, shCb, cnt, actPer;
  logic             dirUp;
  logic [N_OUT-1:0] pwmOut;

  pwm_act_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .stb       (stb),
    .cfg       (cfg),
    .shPer     (shPer),
    .shCa      (shCa),
    .shCb      (shCb)
  );

  pwm_act_dp #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cfg    (cfg),
    .shPer  (shPer),
    .shCa   (shCa),
    .shCb   (shCb),
    .pwmOut (pwmOut),
    .cnt    (cnt),
    .actPer (actPer),
    .dirUp  (dirUp)
  );

  assign pwmOutA = pwmOut[0];
  assign pwmOutB = pwmOut[1];

endmodule

// File: rtl/pwm_act_chk.sv
module pwm_act_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             tick,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] actPer,
  input logic             dirUp,
  input logic             outA,
  input logic             outB,
  input logic             idleA,
  input logic             idleB
);

  AST_IDLE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (outA == idleA && outB == idleB)); // R2

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) |=> (!run || $stable(cnt))); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (run && actPer != '0) |-> (cnt <= actPer)); // R4

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && mode == 2'd0 && cnt < actPer) |=> (!run || cnt == $past(cnt) + 1'b1)); // R4

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && mode == 2'd0 && cnt == actPer) |=> (!run || cnt == '0)); // R4

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && mode == 2'd1 && cnt != '0) |=> (!run || cnt == $past(cnt) - 1'b1)); // R5

  AST_UD_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (run && tick && mode == 2'd2 && dirUp && cnt == actPer && cnt != '0) |=> (!run || !dirUp)); // R6

endmodule

bind pwm_action_channel pwm_act_chk #(.CNT_W(CNT_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .run    (stb.run),
  .tick   (stb.tick),
  .mode   (cfg.mode),
  .cnt    (cnt),
  .actPer (actPer),
  .dirUp  (dirUp),
  .outA   (pwmOutA),
  .outB   (pwmOutB),
  .idleA  (cfg.idle[0]),
  .idleB  (cfg.idle[1])
);

// File: tb/pwm_action_channel_tb.sv
module pwm_action_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        pwmOutA, pwmOutB;

  int nChk = 0;
  int nErr = 0;
  logic expLv [0:1][0:127];

  always #4 clk = ~clk;

  pwm_action_channel dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .pwmOutA   (pwmOutA),
    .pwmOutB   (pwmOutB)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic wrReg(input int addr, input logic [15:0] data);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgAddr   = 3'(addr);
    cfgWrData = data;
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  function automatic logic [15:0] ctrlWord(input logic run, input int mode,
                                           input logic [1:0] pol, input logic [1:0] idle);
    return {9'd0, idle, pol, 2'(mode), run};
  endfunction

  // reference: levels after n ticks, from counting rules and action tables
  task automatic buildModel(input int mode, input int per, input int ca, input int cb,
                            input logic [11:0] tA, input logic [11:0] tB,
                            input int nt, input int chgTick, input int newPer);
    int cnt, dirUp, actPer, shPer, du, idx, nxt;
    logic wasZero;
    logic [1:0] lv, a;
    logic [11:0] tb;
    shPer = per; actPer = per;
    cnt = (mode == 1) ? per : 0;
    dirUp = 1; lv = 2'b00;
    expLv[0][0] = 1'b0; expLv[1][0] = 1'b0;
    for (int t = 0; t < nt; t++) begin
      if (t == chgTick) shPer = newPer;
      du = (mode == 0) ? 1 : (mode == 1) ? 0 : dirUp;
      if (cnt == 0) idx = 0;
      else if (cnt == actPer) idx = 1;
      else if (cnt == cb) idx = du ? 2 : 3;
      else if (cnt == ca) idx = du ? 4 : 5;
      else idx = -1;
      for (int o = 0; o < 2; o++) begin
        tb = (o == 1) ? tB : tA;
        if (idx >= 0) begin
          a = 2'(tb >> (2 * idx));
          case (a)
            2'd1: lv[o] = 1'b0;
            2'd2: lv[o] = 1'b1;
            2'd3: lv[o] = ~lv[o];
            default: ;
          endcase
        end
      end
      wasZero = (cnt == 0);
      if (mode == 0) nxt = (cnt >= actPer) ? 0 : cnt + 1;
      else if (mode == 1) nxt = (cnt == 0) ? shPer : cnt - 1;
      else if (dirUp == 1) begin
        if (cnt >= actPer) begin dirUp = 0; nxt = (cnt == 0) ? 0 : cnt - 1; end
        else nxt = cnt + 1;
      end else begin
        if (cnt == 0) begin dirUp = 1; nxt = (shPer == 0) ? 0 : 1; end
        else nxt = cnt - 1;
      end
      cnt = nxt;
      if (wasZero) actPer = shPer;
      expLv[0][t+1] = lv[0];
      expLv[1][t+1] = lv[1];
    end
  endtask

  task automatic runCase(input string tag, input int mode, input int per, input int ca, input int cb,
                         input logic [11:0] tA, input logic [11:0] tB,
                         input logic [1:0] pol, input logic [1:0] idle,
                         input int presc, input int ncyc, input int wrCyc, input int newPer);
    int chgTick, nt, n;
    logic wrPend;
    wrReg(0, ctrlWord(1'b0, mode, pol, idle));
    // R1: control fields land in place; idle bits show while stopped
    check("R1", pwmOutA, idle[0], "idle A after control write");
    check("R1", pwmOutB, idle[1], "idle B after control write");
    wrReg(1, 16'(presc));
    wrReg(2, 16'(per));
    wrReg(3, 16'(ca));
    wrReg(4, 16'(cb));
    wrReg(5, {4'd0, tA});
    wrReg(6, {4'd0, tB});
    if (wrCyc < 0) chgTick = 1 << 20;
    else if (wrCyc < presc) chgTick = 0;
    else chgTick = (wrCyc - presc) / (presc + 1) + 1;
    nt = ncyc / (presc + 1) + 1;
    buildModel(mode, per, ca, cb, tA, tB, nt, chgTick, newPer);
    wrReg(0, ctrlWord(1'b1, mode, pol, idle));
    wrPend = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      n = c / (presc + 1);
      check(tag, pwmOutA, expLv[0][n] ^ pol[0], "output A");
      check("R12", pwmOutB, expLv[1][n] ^ pol[1], "output B");
      if (wrPend) begin cfgWrEn = 1'b0; wrPend = 1'b0; end
      if (c == wrCyc) begin
        cfgWrEn = 1'b1; cfgAddr = 3'd2; cfgWrData = 16'(newPer); wrPend = 1'b1;
      end
      @(negedge clk);
    end
    cfgWrEn = 1'b0;
    wrReg(0, ctrlWord(1'b0, mode, pol, idle));
    check("R2", pwmOutA, idle[0], "idle A after stop");
    check("R2", pwmOutB, idle[1], "idle B after stop");
  endtask

  logic [11:0] tblA [0:3];
  logic [11:0] tblB [0:3];
  int cmpA [0:3];
  int cmpB [0:3];

  initial begin
    string tag;
    tblA[0] = 12'h902; tblB[0] = 12'h064;
    tblA[1] = 12'hFFF; tblB[1] = 12'h3C3;
    tblA[2] = 12'h0F0; tblB[2] = 12'hC0C;
    tblA[3] = 12'h6A9; tblB[3] = 12'h9E7;
    cmpA[0] = 2; cmpB[0] = 4;
    cmpA[1] = 3; cmpB[1] = 3;   // B over A
    cmpA[2] = 4; cmpB[2] = 6;   // period over B
    cmpA[3] = 0; cmpB[3] = 5;   // zero over A

    repeat (3) @(negedge clk);
    check("R2", pwmOutA, 1'b0, "reset idle A");
    check("R2", pwmOutB, 1'b0, "reset idle B");
    rstN = 1'b1;
    @(negedge clk);
    check("R2", pwmOutA, 1'b0, "post-reset A");
    check("R2", pwmOutB, 1'b0, "post-reset B");

    // R8: each action code with distinct field positions
    runCase("R8", 0, 5, 2, 4, 12'h006, 12'h00F, 2'b00, 2'b10, 0, 30, -1, 0);
    // R7: compare B rises high counting up, low counting down
    runCase("R7", 2, 6, 1, 3, 12'h060, 12'h300, 2'b00, 2'b01, 0, 40, -1, 0);
    // R11: mid-run period change for each mode
    runCase("R11", 0, 6, 2, 4, 12'h003, 12'h00C, 2'b00, 2'b00, 0, 50, 9, 3);
    runCase("R11", 1, 6, 2, 4, 12'h003, 12'h00C, 2'b00, 2'b00, 0, 50, 9, 3);
    runCase("R11", 2, 6, 2, 4, 12'h003, 12'h00C, 2'b00, 2'b00, 1, 60, 11, 3);

    // sweep: modes (R4, R5, R6), tables, compare layouts (R9), polarity (R10), prescale (R3)
    for (int m = 0; m < 3; m++)
      for (int ti = 0; ti < 4; ti++)
        for (int ci = 0; ci < 4; ci++)
          for (int pi = 0; pi < 2; pi++)
            for (int si = 0; si < 2; si++) begin
              if (ci != 0) tag = "R9";
              else if (si != 0) tag = "R3";
              else if (pi != 0) tag = "R10";
              else if (m == 0) tag = "R4";
              else if (m == 1) tag = "R5";
              else tag = "R6";
              runCase(tag, m, 6, cmpA[ci], cmpB[ci], tblA[ti], tblB[ti],
                      pi ? 2'b11 : 2'b00, 2'b01, si ? 2 : 0, 60, -1, 0);
            end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nErr++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule